// File: doc/BRIEF.md
# Condition Flags and Predicate Gate

This block keeps the processor's 32-bit status word and decides, for every instruction in the issue stage, whether it should run or be turned into a no-op. The status word holds four condition flags (negative, zero, carry, overflow) in its top four bits and a 5-bit processor mode in its bottom five bits. Every instruction carries a 4-bit condition code. The block evaluates that code against the stored flags in the same cycle and drives a single execute/squash signal back to the pipeline.

The flags change in two ways. An executed instruction that asks for it writes the flags: an ordinary operation with its set-flags bit loads the ALU's result flags, and a compare loads flags computed inside the block from the difference of its two operands. A dedicated write port can also replace the whole word. A read port returns the word at any time. An instruction that is squashed, or a cycle with no valid instruction, leaves the word as it was.

Top module: `psw_pred_unit`

## Requirements
- R1: After reset the status word reads 0x00000013: all flags are 0, bits 27 to 5 are 0, and the mode field holds the RESET_MODE parameter (default 5'b10011).
- R2: The status word places N at bit 31, Z at bit 30, C at bit 29 and V at bit 28. The processor mode is in bits 4 down to 0.
- R3: `exec_ok` is true for each condition code as follows, where N, Z, C and V are the stored flags:

  | Code | Condition | Code | Condition |
  |------|-----------|------|-----------|
  | 0000 | Z | 1000 | C and not Z |
  | 0001 | not Z | 1001 | not C or Z |
  | 0010 | C | 1010 | N equals V |
  | 0011 | not C | 1011 | N differs from V |
  | 0100 | N | 1100 | not Z and N equals V |
  | 0101 | not N | 1101 | Z or N differs from V |
  | 0110 | V | | |
  | 0111 | not V | | |

- R4: Code 1110 always gives `exec_ok`=1 and code 1111 always gives `exec_ok`=0, whatever the flags.
- R5: An executed non-compare instruction (`instr_valid`=1, `exec_ok`=1, `set_flags`=1, `is_compare`=0) loads the ALU flags {`alu_n`,`alu_z`,`alu_c`,`alu_v`} into bits 31:28 at the next clock edge.
- R6: An instruction with neither `set_flags` nor `is_compare` leaves the flags unchanged.
- R7: An executed compare updates the flags whether or not `set_flags` is high, and it ignores the ALU flags. The flags come from D = `cmp_a` − `cmp_b` (modulo 2^DATA_W): N is the top bit of D, Z is 1 when D is 0, C is 1 when no borrow occurs (`cmp_a` ≥ `cmp_b` unsigned), and V is 1 on signed overflow of the subtraction.
- R8: When `exec_ok` is 0 or `instr_valid` is 0, no flag changes, even if a flag update is requested.
- R9: When `psw_wr_en` is high, the whole word is replaced by `psw_wr_data` at the next edge, and this takes priority over any flag update in the same cycle. Bits 27:0 change only through this port.
- R10: `exec_ok` and `psw_rd_data` are combinational functions of the stored word, so they do not depend on `instr_valid`. A flag update or a port write becomes visible in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is being evaluated this cycle |
| cond_code | input | 4 | Condition field of the instruction |
| set_flags | input | 1 | Instruction requests a flag update |
| is_compare | input | 1 | Instruction is compare-class |
| alu_n | input | 1 | ALU result negative flag |
| alu_z | input | 1 | ALU result zero flag |
| alu_c | input | 1 | ALU result carry flag |
| alu_v | input | 1 | ALU result overflow flag |
| cmp_a | input | DATA_W | Compare first operand |
| cmp_b | input | DATA_W | Compare second operand (subtracted) |
| psw_wr_en | input | 1 | Replace the status word |
| psw_wr_data | input | 32 | New status word |
| psw_rd_data | output | 32 | Current status word |
| exec_ok | output | 1 | 1 = execute, 0 = squash to no-op |

## Verification
A corrupted flag bit shows up at `psw_rd_data` in the cycle after the faulty edge. It also flips `exec_ok` in that same cycle for any condition code that depends on the bit. Because of this, the bench checks both outputs every cycle against a reference word: it does not wait for a later branch-like instruction to reveal the error. A mistake in one predicate is only visible while its code is presented with a flag combination that tells the codes apart. Random codes over random flag words, plus directed checks of the two fixed codes, cover this. Errors in compare flag generation show up one cycle after a valid compare. Directed operand pairs target the borrow boundary and the signed overflow boundary.

// File: rtl/psw_pkg.sv
package psw_pkg;

   localparam int PSW_W   = 32;
   localparam int FLAG_N  = 31;
   localparam int FLAG_Z  = 30;
   localparam int FLAG_C  = 29;
   localparam int FLAG_V  = 28;
   localparam int MODE_W  = 5;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   typedef enum logic [3:0] {
      CC_EQ = 4'b0000, CC_NE = 4'b0001, CC_CS = 4'b0010, CC_CC = 4'b0011,
      CC_MI = 4'b0100, CC_PL = 4'b0101, CC_VS = 4'b0110, CC_VC = 4'b0111,
      CC_HI = 4'b1000, CC_LS = 4'b1001, CC_GE = 4'b1010, CC_LT = 4'b1011,
      CC_GT = 4'b1100, CC_LE = 4'b1101, CC_AL = 4'b1110, CC_NV = 4'b1111
   } cond_e;

   // The low code bit inverts the sense of each base test, except for AL/NV.
   function automatic logic cond_holds(input logic [3:0] code, input flags_t f);
      logic base;
      unique case (code[3:1])
         3'd0: base = f.z;
         3'd1: base = f.c;
         3'd2: base = f.n;
         3'd3: base = f.v;
         3'd4: base = f.c & ~f.z;
         3'd5: base = (f.n == f.v);
         3'd6: base = ~f.z & (f.n == f.v);
         default: base = 1'b1;
      endcase
      return base ^ code[0];
   endfunction

endpackage

// File: rtl/psw_cond_eval.sv
module psw_cond_eval
   import psw_pkg::*;
(
   input  logic [3:0] cond,
   input  flags_t     flags,
   output logic       pass
);

   localparam int N_COND = 16;

   logic [N_COND-1:0] pred_vec;

   // One predicate line per condition code, then select by the code.
   for (genvar gi = 0; gi < N_COND; gi++) begin : g_pred
      assign pred_vec[gi] = cond_holds(4'(gi), flags);
   end

   assign pass = pred_vec[cond];

   always_comb begin
      if (cond == CC_AL) AST_AL_TRUE:  assert (pass == 1'b1);            // R4
      if (cond == CC_NV) AST_NV_FALSE: assert (pass == 1'b0);            // R4
      if (cond == CC_EQ) AST_EQ_ZSET:  assert (pass == flags.z);         // R3
      if (cond == CC_NE) AST_NE_ZCLR:  assert (pass == !flags.z);        // R3
   end

endmodule

// File: rtl/psw_cmp_flags.sv
module psw_cmp_flags
   import psw_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output flags_t            flags
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W:0]   ext_diff;
   logic [DATA_W-1:0] diff;

   // Extended subtraction: the top bit is the borrow out.
   assign ext_diff = {1'b0, op_a} - {1'b0, op_b};
   assign diff     = ext_diff[MSB:0];

   assign flags.n = diff[MSB];
   assign flags.z = (diff == '0);
   assign flags.c = ~ext_diff[DATA_W];
   assign flags.v = (op_a[MSB] ^ op_b[MSB]) & (diff[MSB] ^ op_a[MSB]);

endmodule

// File: rtl/psw_store.sv
module psw_store
   import psw_pkg::*;
#(
   parameter logic [MODE_W-1:0] RESET_MODE = 5'b10011
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PSW_W-1:0] wr_data,
   input  logic             upd_en,
   input  flags_t           upd_flags,
   output logic [PSW_W-1:0] word
);

   localparam logic [PSW_W-1:0] RESET_WORD = {{(PSW_W-MODE_W){1'b0}}, RESET_MODE};

   logic [PSW_W-1:0] word_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         word_q <= RESET_WORD;
      else if (wr_en)
         word_q <= wr_data;
      else if (upd_en)
         word_q[FLAG_N:FLAG_V] <= upd_flags;
   end

   assign word = word_q;

   AST_WR_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> word == $past(wr_data));                                  // R9
   AST_LOW_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(word[FLAG_V-1:0]));                             // R9

endmodule

// File: rtl/psw_pred_unit.sv
module psw_pred_unit
   import psw_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter logic [MODE_W-1:0] RESET_MODE = 5'b10011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [3:0]        cond_code,
   input  logic              set_flags,
   input  logic              is_compare,
   input  logic              alu_n,
   input  logic              alu_z,
   input  logic              alu_c,
   input  logic              alu_v,
   input  logic [DATA_W-1:0] cmp_a,
   input  logic [DATA_W-1:0] cmp_b,
   input  logic              psw_wr_en,
   input  logic [31:0]       psw_wr_data,
   output logic [31:0]       psw_rd_data,
   output logic              exec_ok
);

   if (DATA_W < 2) begin : g_bad_width
      $error("psw_pred_unit: DATA_W must be at least 2");
   end
   if (PSW_W != 32) begin : g_bad_psw
      $error("psw_pred_unit: status word must be 32 bits");
   end

   logic [PSW_W-1:0] word;
   flags_t           cur_flags;
   flags_t           cmp_flags;
   flags_t           alu_flags;
   flags_t           next_flags;
   logic             upd_en;

   assign cur_flags = word[FLAG_N:FLAG_V];
   assign alu_flags = '{n: alu_n, z: alu_z, c: alu_c, v: alu_v};

   psw_cond_eval u_cond (
      .cond  (cond_code),
      .flags (cur_flags),
      .pass  (exec_ok)
   );

   psw_cmp_flags #(.DATA_W(DATA_W)) u_cmp (
      .op_a  (cmp_a),
      .op_b  (cmp_b),
      .flags (cmp_flags)
   );

   // A compare always writes the flags; an ordinary op only when asked to.
   // A squashed or absent instruction writes nothing.
   assign upd_en     = instr_valid & exec_ok & (set_flags | is_compare);
   assign next_flags = is_compare ? cmp_flags : alu_flags;

   psw_store #(.RESET_MODE(RESET_MODE)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (psw_wr_en),
      .wr_data   (psw_wr_data),
      .upd_en    (upd_en),
      .upd_flags (next_flags),
      .word      (word)
   );

   assign psw_rd_data = word;

   AST_SQUASH_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (!(instr_valid && exec_ok) && !psw_wr_en) |=> $stable(psw_rd_data[31:28]));      // R8
   AST_NO_REQUEST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_flags && !is_compare && !psw_wr_en) |=> $stable(psw_rd_data[31:28]));      // R6
   AST_ALU_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && exec_ok && set_flags && !is_compare && !psw_wr_en)
      |=> psw_rd_data[31:28] == $past({alu_n, alu_z, alu_c, alu_v}));               // R5
   AST_CMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && exec_ok && is_compare && !psw_wr_en)
      |=> psw_rd_data[30] == ($past(cmp_a) == $past(cmp_b)));                        // R7
   AST_CMP_NOBORROW: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && exec_ok && is_compare && !psw_wr_en)
      |=> psw_rd_data[29] == ($past(cmp_a) >= $past(cmp_b)));                        // R7

endmodule

// File: tb/psw_pred_unit_tb_top.sv
module psw_pred_unit_tb_top;

   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          instr_valid = 1'b0;
   logic [3:0]    cond_code = 4'd0;
   logic          set_flags = 1'b0;
   logic          is_compare = 1'b0;
   logic          alu_n = 1'b0, alu_z = 1'b0, alu_c = 1'b0, alu_v = 1'b0;
   logic [DW-1:0] cmp_a = '0, cmp_b = '0;
   logic          psw_wr_en = 1'b0;
   logic [31:0]   psw_wr_data = '0;
   logic [31:0]   psw_rd_data;
   logic          exec_ok;

   int            checks = 0;
   int            failures = 0;
   logic [31:0]   exp_psw;
   string         pend_tag;
   bit            done = 0;
   int            cyc = 0;

   always #2 clk = ~clk;

   psw_pred_unit #(.DATA_W(DW)) dut_i (
      .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid),
      .cond_code (cond_code), .set_flags (set_flags), .is_compare (is_compare),
      .alu_n (alu_n), .alu_z (alu_z), .alu_c (alu_c), .alu_v (alu_v),
      .cmp_a (cmp_a), .cmp_b (cmp_b), .psw_wr_en (psw_wr_en),
      .psw_wr_data (psw_wr_data), .psw_rd_data (psw_rd_data), .exec_ok (exec_ok)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 200000 && !done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog act=%0d exp=<200000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // Reference predicate taken straight from the condition table.
   function automatic logic ref_pred(input logic [3:0] cc, input logic [31:0] w);
      logic n, z, c, v;
      {n, z, c, v} = w[31:28];
      case (cc)
         4'd0:  return z;
         4'd1:  return !z;
         4'd2:  return c;
         4'd3:  return !c;
         4'd4:  return n;
         4'd5:  return !n;
         4'd6:  return v;
         4'd7:  return !v;
         4'd8:  return c && !z;
         4'd9:  return !c || z;
         4'd10: return n == v;
         4'd11: return n != v;
         4'd12: return !z && (n == v);
         4'd13: return z || (n != v);
         4'd14: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [3:0] ref_cmp(input logic [DW-1:0] a, input logic [DW-1:0] b);
      logic [DW-1:0] d;
      d = a - b;
      return {d[DW-1], d == '0, a >= b,
              (a[DW-1] != b[DW-1]) && (d[DW-1] != a[DW-1])};
   endfunction

   // One cycle: check the word left by the previous edge, drive, check the predicate.
   task automatic step(input string tag, input logic v, input logic [3:0] cc,
                       input logic s, input logic cm, input logic [3:0] af,
                       input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic we, input logic [31:0] wd);
      logic ok;
      @(negedge clk);
      chk(pend_tag, psw_rd_data, exp_psw);
      instr_valid = v; cond_code = cc; set_flags = s; is_compare = cm;
      {alu_n, alu_z, alu_c, alu_v} = af;
      cmp_a = a; cmp_b = b; psw_wr_en = we; psw_wr_data = wd;
      #1;
      ok = ref_pred(cc, exp_psw);
      chk((cc >= 4'd14) ? "R4" : "R3", {31'd0, exec_ok}, {31'd0, ok});
      if (we)                          exp_psw = wd;
      else if (v && ok && cm)          exp_psw[31:28] = ref_cmp(a, b);
      else if (v && ok && s)           exp_psw[31:28] = af;
      pend_tag = tag;
   endtask

   task automatic idle(input string tag);
      step(tag, 1'b0, 4'd14, 1'b0, 1'b0, 4'd0, '0, '0, 1'b0, '0);
   endtask

   initial begin
      logic [31:0] seed_dummy;
      seed_dummy = $urandom(32'd7341);
      exp_psw  = 32'h0000_0013;
      pend_tag = "R1";
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1", psw_rd_data, 32'h0000_0013);

      // R2: bit positions seen through the predicates
      step("R9", 1'b0, 4'd0, 1'b0, 1'b0, 4'd0, '0, '0, 1'b1, 32'hA000_0005);
      step("R2", 1'b0, 4'd4, 1'b0, 1'b0, 4'd0, '0, '0, 1'b0, '0); // MI: N at bit 31
      step("R2", 1'b0, 4'd2, 1'b0, 1'b0, 4'd0, '0, '0, 1'b0, '0); // CS: C at bit 29
      step("R2", 1'b0, 4'd0, 1'b0, 1'b0, 4'd0, '0, '0, 1'b0, '0); // EQ: Z clear
      step("R2", 1'b0, 4'd6, 1'b0, 1'b0, 4'd0, '0, '0, 1'b0, '0); // VS: V clear

      // R4: fixed codes under every flag pattern
      for (int f = 0; f < 16; f++) begin
         step("R9", 1'b0, 4'd14, 1'b0, 1'b0, 4'd0, '0, '0, 1'b1, {f[3:0], 28'h13});
         step("R4", 1'b1, 4'd15, 1'b1, 1'b1, 4'hF, 32'd1, 32'd2, 1'b0, '0);
         step("R4", 1'b0, 4'd14, 1'b0, 1'b0, 4'd0, '0, '0, 1'b0, '0);
      end

      // R7: compare corners, set_flags low, ALU flags as decoys
      step("R7", 1'b1, 4'd14, 1'b0, 1'b1, 4'hF, 32'd5, 32'd5, 1'b0, '0);
      step("R7", 1'b1, 4'd14, 1'b0, 1'b1, 4'h4, 32'd0, 32'd1, 1'b0, '0);
      step("R7", 1'b1, 4'd14, 1'b0, 1'b1, 4'h0, 32'h8000_0000, 32'd1, 1'b0, '0);
      step("R7", 1'b1, 4'd14, 1'b1, 1'b1, 4'h0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, '0);
      step("R7", 1'b1, 4'd14, 1'b0, 1'b1, 4'h0, 32'd9, 32'd3, 1'b0, '0);
      // R5 / R6
      step("R5", 1'b1, 4'd14, 1'b1, 1'b0, 4'hB, '0, '0, 1'b0, '0);
      step("R6", 1'b1, 4'd14, 1'b0, 1'b0, 4'h4, '0, '0, 1'b0, '0);
      idle("R6");
      // R8: squashed compare (NV) and invalid slot
      step("R8", 1'b1, 4'd15, 1'b1, 1'b1, 4'h0, 32'd1, 32'd1, 1'b0, '0);
      step("R8", 1'b0, 4'd14, 1'b1, 1'b1, 4'hF, 32'd1, 32'd1, 1'b0, '0);
      idle("R8");
      // R9: write port beats a same-cycle compare
      step("R9", 1'b1, 4'd14, 1'b1, 1'b1, 4'hF, 32'd1, 32'd1, 1'b1, 32'h1234_5678);
      idle("R9");
      // R10: update visible next cycle for a dependent code
      step("R10", 1'b1, 4'd14, 1'b0, 1'b1, 4'h0, 32'd4, 32'd4, 1'b0, '0);
      step("R10", 1'b1, 4'd0, 1'b0, 1'b0, 4'h0, '0, '0, 1'b0, '0);

      // Random mix
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         r = $urandom;
         step(r[2] ? "R7" : "R5", r[0] | r[1], 4'($urandom), r[3], r[4] & r[5],
              4'($urandom), (r[6] ? 32'($urandom) : 32'(r[15:8])),
              (r[7] ? 32'($urandom) : 32'(r[23:16])),
              (r[31:28] == 4'd0), $urandom);
      end
      idle("R6");
      @(negedge clk);
      chk(pend_tag, psw_rd_data, exp_psw);

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule